// File: doc/BRIEF.md
# Burst Write Sequence Checker

This block is a bus slave with a classic cycle/strobe/acknowledge handshake. It watches write bursts aimed at a 4 KB check window and compares each accepted write beat against an expected address and an expected data word. A tracker generates these expected values itself. Software programs the first address, the first data word and a sequence length through registers. After each checked beat the expected address steps forward by one word, and the expected data word rotates left by one bit. When the programmed number of beats has been checked, the tracker returns to the programmed start values and counts one completed burst.

Two sticky flags record mismatches. One is for the address and one is for the data, and both stay set until software clears them. Address bit 12 splits the space. When it is low, the access goes to the check window. When it is high, the access goes to the control and status registers. Writes into the check window are only compared. They are not stored, and reads of the window return zero. A typical test loads the registers, issues bursts, and reads the error status and the burst count back.

Top module: `burst_seq_checker`

## Requirements
- R1: The start address (12 bits, offset 0x1000), start data (32 bits, offset 0x1004) and sequence length (11 bits, offset 0x1008) registers each read back the value last written, zero-extended. All three reset to zero.
- R2: Each checked beat advances the expected address by 4, modulo 4096. A beat whose low 12 address bits differ from the expected address sets the address-mismatch flag.
- R3: Each checked beat rotates the expected data word left by one bit. A beat whose data differs from the expected word sets the data-mismatch flag.
- R4: After the programmed number of beats has been checked, the expected address and data return to the start values, so a following write to the start address with the start data raises no error. A length of 0 acts as 2048.
- R5: A read at offset 0x100C returns the address-mismatch flag in bit 1 and the data-mismatch flag in bit 0, with bits 31:2 reading zero. Both flags reset to zero.
- R6: The mismatch flags are sticky. Later error-free beats leave them set.
- R7: Writing 0xFFFFFFFF to offset 0x100C clears both flags. Writing any other value there leaves them unchanged.
- R8: The burst count at offset 0x1010 increments once each time a full sequence completes. Writing 0xFFFFFFFF to that offset makes it read back zero.
- R9: Bit 12 of the address is 0 for the check window and 1 for the registers, and bits 11:0 index within the space. Writes to the window never change a register, and reads of the window return zero.
- R10: A beat is checked only when cycle, strobe, write-enable and acknowledge are all high with all four byte selects set. Reads, and writes with partial byte selects, neither set flags nor advance the tracker.
- R11: Writing the start address, start data or length register reloads the tracker, so the next checked beat is compared against the start values.
- R12: The acknowledge rises in the cycle after a request with cycle and strobe high is seen, and stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 13 | Byte address; bit 12 selects registers |
| wb_sel_i | input | 4 | Byte selects |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Transfer acknowledge |

## Verification
The embedded assertions check several rules on every cycle: the one-cycle acknowledge pulse, the word step and the one-bit rotation of the expected values on each ordinary checked beat, the reload to the start values at the end of a sequence, the stickiness of the flags, and the zeroing of the burst count after a clear. Other behaviours can only be shown by the bench scenarios. These are the bit positions in the status word, reads of the window returning zero, partial-select writes and reads leaving the tracker unchanged, the effect of reprogramming in the middle of a burst, and the burst count over a series of one-beat sequences. All of these are seen only through register reads after a stimulus.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int ADR_W  = 13;
  localparam int DAT_W  = 32;
  localparam int SEL_W  = DAT_W / 8;
  localparam int OFS_W  = ADR_W - 1;
  localparam int IDX_W  = OFS_W - 2;
  localparam int SIZE_W = 11;

  localparam logic [IDX_W-1:0] IDX_SADR  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_SDAT  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LEN   = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_ERR   = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_BURST = IDX_W'(4);

  typedef struct packed {
    logic             valid;
    logic             we;
    logic             reg_space;
    logic             full_sel;
    logic [OFS_W-1:0] ofs;
    logic [DAT_W-1:0] wdat;
  } beat_t;
endpackage

// File: rtl/bsc_wb_front.sv
module bsc_wb_front
  import bsc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [ADR_W-1:0] adr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DAT_W-1:0] dat_i,
  input  logic [DAT_W-1:0] rdata_i,
  output beat_t            beat_o,
  output logic             ack_o,
  output logic [DAT_W-1:0] dat_o
);
  logic             ack_q, ack_d;
  logic [DAT_W-1:0] dat_q, dat_d;
  logic             req;

  assign req = cyc_i & stb_i;

  always_comb begin
    ack_d = req & ~ack_q;
    dat_d = dat_q;
    if (ack_d) dat_d = we_i ? '0 : rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= ack_d;
      dat_q <= dat_d;
    end
  end

  always_comb begin
    beat_o.valid     = req & ack_q;
    beat_o.we        = we_i;
    beat_o.reg_space = adr_i[ADR_W-1];
    beat_o.full_sel  = &sel_i;
    beat_o.ofs       = adr_i[OFS_W-1:0];
    beat_o.wdat      = dat_i;
  end

  assign ack_o = ack_q;
  assign dat_o = dat_q;

  a_r12_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r12_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && stb_i && !ack_o) |=> ack_o);
endmodule

// File: rtl/bsc_regs.sv
module bsc_regs
  import bsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  beat_t             beat_i,
  input  logic              err_adr_i,
  input  logic              err_dat_i,
  input  logic [CNT_W-1:0]  burst_i,
  output logic [OFS_W-1:0]  start_adr_o,
  output logic [DAT_W-1:0]  start_dat_o,
  output logic [SIZE_W-1:0] len_o,
  output logic              load_o,
  output logic              clr_err_o,
  output logic              clr_burst_o,
  output logic [DAT_W-1:0]  rdata_o
);
  logic [OFS_W-1:0]  sadr_q, sadr_d;
  logic [DAT_W-1:0]  sdat_q, sdat_d;
  logic [SIZE_W-1:0] len_q, len_d;
  logic              load_q, load_d;
  logic              wr, ones;
  logic [IDX_W-1:0]  idx;

  assign idx  = beat_i.ofs[OFS_W-1:2];
  assign wr   = beat_i.valid & beat_i.we & beat_i.reg_space & beat_i.full_sel;
  assign ones = &beat_i.wdat;

  always_comb begin
    sadr_d = sadr_q;
    sdat_d = sdat_q;
    len_d  = len_q;
    load_d = 1'b0;
    if (wr) begin
      unique case (idx)
        IDX_SADR: begin sadr_d = beat_i.wdat[OFS_W-1:0];  load_d = 1'b1; end
        IDX_SDAT: begin sdat_d = beat_i.wdat;             load_d = 1'b1; end
        IDX_LEN:  begin len_d  = beat_i.wdat[SIZE_W-1:0]; load_d = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sadr_q <= '0;
      sdat_q <= '0;
      len_q  <= '0;
      load_q <= 1'b0;
    end else begin
      sadr_q <= sadr_d;
      sdat_q <= sdat_d;
      len_q  <= len_d;
      load_q <= load_d;
    end
  end

  assign clr_err_o   = wr & (idx == IDX_ERR) & ones;
  assign clr_burst_o = wr & (idx == IDX_BURST) & ones;
  assign load_o      = load_q;
  assign start_adr_o = sadr_q;
  assign start_dat_o = sdat_q;
  assign len_o       = len_q;

  always_comb begin
    rdata_o = '0;
    if (beat_i.reg_space) begin
      unique case (idx)
        IDX_SADR:  rdata_o = DAT_W'(sadr_q);
        IDX_SDAT:  rdata_o = sdat_q;
        IDX_LEN:   rdata_o = DAT_W'(len_q);
        IDX_ERR:   rdata_o = {{(DAT_W-2){1'b0}}, err_adr_i, err_dat_i};
        IDX_BURST: rdata_o = DAT_W'(burst_i);
        default:   rdata_o = '0;
      endcase
    end
  end

  a_r9_window_write_keeps_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i.valid && beat_i.we && !beat_i.reg_space) |=> (sadr_q == $past(sadr_q) && sdat_q == $past(sdat_q) && len_q == $past(len_q)));
endmodule

// File: rtl/bsc_seq_track.sv
module bsc_seq_track
  import bsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  beat_t             beat_i,
  input  logic [OFS_W-1:0]  start_adr_i,
  input  logic [DAT_W-1:0]  start_dat_i,
  input  logic [SIZE_W-1:0] len_i,
  input  logic              load_i,
  input  logic              clr_err_i,
  input  logic              clr_burst_i,
  output logic              err_adr_o,
  output logic              err_dat_o,
  output logic [CNT_W-1:0]  burst_o
);
  logic [OFS_W-1:0]  exp_adr_q, exp_adr_d;
  logic [DAT_W-1:0]  exp_dat_q, exp_dat_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0]  burst_q, burst_d;
  logic              eadr_q, eadr_d, edat_q, edat_d;
  logic              chk, wrap;

  assign chk     = beat_i.valid & beat_i.we & ~beat_i.reg_space & beat_i.full_sel;
  assign cnt_inc = cnt_q + SIZE_W'(1);
  assign wrap    = (cnt_inc == len_i);

  always_comb begin
    exp_adr_d = exp_adr_q;
    exp_dat_d = exp_dat_q;
    cnt_d     = cnt_q;
    burst_d   = burst_q;
    eadr_d    = eadr_q;
    edat_d    = edat_q;
    if (load_i) begin
      exp_adr_d = start_adr_i;
      exp_dat_d = start_dat_i;
      cnt_d     = '0;
    end else if (chk) begin
      eadr_d = eadr_q | (beat_i.ofs != exp_adr_q);
      edat_d = edat_q | (beat_i.wdat != exp_dat_q);
      if (wrap) begin
        exp_adr_d = start_adr_i;
        exp_dat_d = start_dat_i;
        cnt_d     = '0;
        burst_d   = burst_q + CNT_W'(1);
      end else begin
        exp_adr_d = exp_adr_q + OFS_W'(4);
        exp_dat_d = {exp_dat_q[DAT_W-2:0], exp_dat_q[DAT_W-1]};
        cnt_d     = cnt_inc;
      end
    end
    if (clr_err_i) begin
      eadr_d = 1'b0;
      edat_d = 1'b0;
    end
    if (clr_burst_i) burst_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_adr_q <= '0;
      exp_dat_q <= '0;
      cnt_q     <= '0;
      burst_q   <= '0;
      eadr_q    <= 1'b0;
      edat_q    <= 1'b0;
    end else begin
      exp_adr_q <= exp_adr_d;
      exp_dat_q <= exp_dat_d;
      cnt_q     <= cnt_d;
      burst_q   <= burst_d;
      eadr_q    <= eadr_d;
      edat_q    <= edat_d;
    end
  end

  assign err_adr_o = eadr_q;
  assign err_dat_o = edat_q;
  assign burst_o   = burst_q;

  a_r2_adr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk && !wrap && !load_i) |=> exp_adr_q == $past(beat_i.ofs) + OFS_W'(4) || $past(beat_i.ofs != exp_adr_q));
  a_r3_dat_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk && !wrap && !load_i) |=> (exp_dat_q == {$past(exp_dat_q[DAT_W-2:0]), $past(exp_dat_q[DAT_W-1])}));
  a_r4_reload_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk && wrap) |=> (exp_adr_q == start_adr_i && exp_dat_q == start_dat_i));
  a_r6_adr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eadr_q && !clr_err_i) |=> eadr_q);
  a_r6_dat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edat_q && !clr_err_i) |=> edat_q);
  a_r8_burst_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_burst_i |=> (burst_q == '0));
  a_r10_unchecked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk && !load_i) |=> $stable(exp_adr_q) && $stable(exp_dat_q));
endmodule

// File: rtl/burst_seq_checker.sv
module burst_seq_checker
  import bsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [SEL_W-1:0] wb_sel_i,
  input  logic [DAT_W-1:0] wb_dat_i,
  output logic [DAT_W-1:0] wb_dat_o,
  output logic             wb_ack_o
);
  beat_t             beat;
  logic [DAT_W-1:0]  rdata;
  logic [OFS_W-1:0]  start_adr;
  logic [DAT_W-1:0]  start_dat;
  logic [SIZE_W-1:0] len;
  logic              load, clr_err, clr_burst, err_adr, err_dat;
  logic [CNT_W-1:0]  burst;

  bsc_wb_front u_front (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(wb_cyc_i), .stb_i(wb_stb_i),
    .we_i(wb_we_i), .adr_i(wb_adr_i), .sel_i(wb_sel_i), .dat_i(wb_dat_i),
    .rdata_i(rdata), .beat_o(beat), .ack_o(wb_ack_o), .dat_o(wb_dat_o)
  );

  bsc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .beat_i(beat), .err_adr_i(err_adr),
    .err_dat_i(err_dat), .burst_i(burst), .start_adr_o(start_adr),
    .start_dat_o(start_dat), .len_o(len), .load_o(load),
    .clr_err_o(clr_err), .clr_burst_o(clr_burst), .rdata_o(rdata)
  );

  bsc_seq_track #(.CNT_W(CNT_W)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .beat_i(beat), .start_adr_i(start_adr),
    .start_dat_i(start_dat), .len_i(len), .load_i(load), .clr_err_i(clr_err),
    .clr_burst_i(clr_burst), .err_adr_o(err_adr), .err_dat_o(err_dat),
    .burst_o(burst)
  );
endmodule

// File: tb/burst_seq_checker_tb_top.sv
module burst_seq_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [12:0] adr = '0;
  logic [3:0]  sel = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic        ack;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  localparam logic [12:0] A_SADR = 13'h1000, A_SDAT = 13'h1004, A_LEN = 13'h1008,
                          A_ERR = 13'h100C, A_BURST = 13'h1010;

  always #4 clk = ~clk;

  burst_seq_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack)
  );

  // monitor: pops expected read results as acknowledges appear
  always @(posedge clk) begin
    #2;
    if (ack && cyc && !we) begin
      if (q_exp.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL unexpected read ack: act %h exp none", rdat);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_cmp++;
        if (rdat !== e) begin
          n_bad++;
          $display("FAIL %s: act %h exp %h", t, rdat, e);
        end
      end
    end
  end

  function automatic logic [31:0] rotl(input logic [31:0] v);
    return {v[30:0], v[31]};
  endfunction

  task automatic beat(input logic [12:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; wdat = d; sel = s;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0; sel = '0;
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    beat(a, d, 4'hF);
    idle();
  endtask

  task automatic rd(input logic [12:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    q_exp.push_back(e); q_tag.push_back(tag);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a; sel = 4'hF;
    @(posedge clk);
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0;
  endtask

  // n beats of a correct sequence from (a,d); beat k gets address or data corrupted
  task automatic burst(input logic [11:0] a, input logic [31:0] d, input int n,
                       input int bad_adr_k, input int bad_dat_k);
    logic [11:0] ca = a;
    logic [31:0] cd = d;
    for (int k = 0; k < n; k++) begin
      beat({1'b0, (k == bad_adr_k) ? ca ^ 12'h040 : ca}, (k == bad_dat_k) ? ~cd : cd, 4'hF);
      ca = ca + 12'd4;
      cd = rotl(cd);
    end
    idle();
  endtask

  task automatic setup(input logic [11:0] a, input logic [31:0] d, input logic [10:0] n);
    wr(A_SADR, {20'h0, a});
    wr(A_SDAT, d);
    wr(A_LEN, {21'h0, n});
    wr(A_ERR, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: act running exp finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // reset state
    rd(A_ERR,   32'h0, "R5 status after reset");
    rd(A_LEN,   32'h0, "R1 length after reset");
    rd(A_BURST, 32'h0, "R8 burst count after reset");
    // register programming and readback
    setup(12'h100, 32'h8000_0001, 11'd4);
    rd(A_SADR, 32'h100,       "R1 start address readback");
    rd(A_SDAT, 32'h8000_0001, "R1 start data readback");
    rd(A_LEN,  32'h4,         "R1 length readback");
    // clean sequence, then return to start
    burst(12'h100, 32'h8000_0001, 4, -1, -1);
    wr(13'h0100, 32'h8000_0001);
    rd(A_ERR,   32'h0, "R2 R3 R4 clean sequence and wrap");
    rd(A_BURST, 32'h1, "R8 one completed sequence");
    // data error on the third beat
    setup(12'h100, 32'h8000_0001, 11'd4);
    burst(12'h100, 32'h8000_0001, 4, -1, 2);
    rd(A_ERR, 32'h1, "R3 data mismatch in bit 0");
    wr(A_ERR, 32'h0000_0001);
    rd(A_ERR, 32'h1, "R7 partial clear value ignored");
    wr(A_ERR, 32'hFFFF_FFFF);
    rd(A_ERR, 32'h0, "R7 clear with all ones");
    // address error on the second beat, then a clean run
    burst(12'h100, 32'h8000_0001, 4, 1, -1);
    rd(A_ERR, 32'h2, "R2 address mismatch in bit 1");
    burst(12'h100, 32'h8000_0001, 4, -1, -1);
    rd(A_ERR, 32'h2, "R6 flag stays set after clean burst");
    // partial byte selects and reads are not checked
    setup(12'h200, 32'h1234_5678, 11'd3);
    beat(13'h0200, 32'hDEAD_BEEF, 4'h3);
    idle();
    rd(13'h0200, 32'h0, "R9 window read returns zero");
    burst(12'h200, 32'h1234_5678, 3, -1, -1);
    rd(A_ERR, 32'h0, "R10 partial select and read leave tracker");
    // window write does not touch registers
    wr(13'h0000, 32'h0000_0ABC);
    rd(A_SADR, 32'h200, "R9 window write leaves start address");
    // reprogram mid-burst reloads
    setup(12'h300, 32'h0000_00F0, 11'd8);
    burst(12'h300, 32'h0000_00F0, 2, -1, -1);
    wr(A_SDAT, 32'h0F00_0000);
    burst(12'h300, 32'h0F00_0000, 3, -1, -1);
    rd(A_ERR, 32'h0, "R11 reprogram reloads tracker");
    // length 1: every beat completes a sequence
    setup(12'hFFC, 32'hA5A5_0001, 11'd1);
    wr(A_BURST, 32'hFFFF_FFFF);
    rd(A_BURST, 32'h0, "R8 clear reads zero");
    burst(12'hFFC, 32'hA5A5_0001, 1, -1, -1);
    burst(12'hFFC, 32'hA5A5_0001, 1, -1, -1);
    burst(12'hFFC, 32'hA5A5_0001, 1, -1, -1);
    rd(A_BURST, 32'h3, "R4 R8 length one counts each beat");
    rd(A_ERR,   32'h0, "R4 length one stays at start");
    // acknowledge is a single cycle
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = A_LEN;
    q_exp.push_back(32'h1); q_tag.push_back("R12 held request read");
    @(posedge clk); @(negedge clk);
    n_cmp++;
    if (ack !== 1'b1) begin n_bad++; $display("FAIL R12 ack high: act %b exp 1", ack); end
    @(posedge clk); @(negedge clk);
    n_cmp++;
    if (ack !== 1'b0) begin n_bad++; $display("FAIL R12 ack drops: act %b exp 0", ack); end
    cyc = 1'b0; stb = 1'b0;
    repeat (3) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule